// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block decides when a 32-bit processor core leaves its normal instruction stream for an exception handler, and how it comes back. It watches six request lines: undefined instruction, software interrupt, prefetch abort, data abort, IRQ and FIQ. It also sees the current program counter and status word. When the core reports that an instruction has completed, the block picks the most urgent request that is not masked. It then drives four writes, one per cycle, onto a single register-file write port. First the status word is saved into the target mode's saved-status slot. Next the status word is rewritten with the new mode and masks. Then the return address goes into the target mode's link slot. Last, the program counter is forced to the cause's vector.

A return request is accepted at an instruction boundary when no exception wins. It drives two writes. The status word is restored from the saved copy that the core presents. The program counter is then loaded with the presented link value minus an adjustment, which depends on the cause most recently entered. Reset is handled as the first exception after reset is released and is never returned from. Fetch, decode and the register storage itself live outside the block.

Top module: `exc_sequencer`

## Requirements
- R1: While `rst_n` is low, `busy` and `wr_en` are 0. After release, a reset sequence runs without waiting for `instr_done`. Its status write is exactly 0x0000_00D3 to bank 5'b10011, and its program-counter write is `VEC_BASE` (0x0000_0000 by default).
- R2: An accepted exception makes `busy` rise in the next cycle. Four consecutive cycles then carry one write each, in this order, using the `wr_kind` codes 0=saved status, 1=status, 2=link, 3=program counter. The saved-status write carries `psr_in` as sampled at acceptance. The link write carries `pc_in` as sampled at acceptance. All four use the target mode as `wr_bank`.
- R3: The program-counter write of an entry is `VEC_BASE` plus 0x00 for reset, 0x04 undefined, 0x08 software interrupt, 0x0C prefetch abort, 0x10 data abort, 0x18 IRQ and 0x1C FIQ.
- R4: The target mode, placed in status bits [4:0] and used as `wr_bank`, is 10001 for FIQ, 10010 for IRQ, 10011 for software interrupt and reset, 10111 for either abort, and 11011 for undefined.
- R5: The new status word is the sampled one with bits [4:0] replaced and bit 7 (IRQ mask) set. Bit 6 (FIQ mask) is also set on FIQ entry. All other bits are copied.
- R6: When several enabled requests are present, the winner is, highest first: data abort, FIQ, IRQ, prefetch abort, undefined, software interrupt.
- R7: Requests and returns are accepted only while `instr_done` is 1 and `busy` is 0. Otherwise they cause no write.
- R8: IRQ is ignored while `psr_in` bit 7 is 1. FIQ is ignored while `psr_in` bit 6 is 1.
- R9: An accepted return gives two consecutive writes. The first is a status write (code 1) of `spsr_in`. The second is a program-counter write (code 3) of `lr_in` minus 4 for prefetch abort, IRQ or FIQ, minus 8 for data abort, and minus 0 for undefined or software interrupt. The adjustment follows the cause of the last completed entry.
- R10: A return request is ignored while the last completed entry was reset. An enabled exception wins over a return request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; its release schedules the reset exception |
| instr_done | input | 1 | Current instruction has completed (acceptance point) |
| req_undef | input | 1 | Undefined-instruction request |
| req_swi | input | 1 | Software-interrupt request |
| req_pabt | input | 1 | Prefetch-abort request |
| req_dabt | input | 1 | Data-abort request |
| req_irq | input | 1 | IRQ request, level |
| req_fiq | input | 1 | FIQ request, level |
| ret_req | input | 1 | Return-from-exception request |
| pc_in | input | 32 | Return address to link on entry |
| psr_in | input | 32 | Current status word |
| spsr_in | input | 32 | Saved status of the current mode, used on return |
| lr_in | input | 32 | Link value of the current mode, used on return |
| busy | output | 1 | A sequence is in progress |
| wr_en | output | 1 | Register write valid this cycle |
| wr_kind | output | 2 | 0 saved status, 1 status, 2 link, 3 program counter |
| wr_bank | output | 5 | Mode code selecting the register bank |
| wr_data | output | 32 | Write data |

## Verification
A wrong step counter shows up at once on the write port. A write arrives with the wrong `wr_kind`, or a fifth write appears, within the cycle after the fault. A wrong priority or mask decision is visible in the first write after acceptance, because the bank and the later vector both name the cause. A stale return cause cannot be seen until the next return. For that reason, every entry in the bench is followed by its own return, so that the adjustment is observed against the cause that was just taken.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  localparam int DATA_W = 32;
  localparam int MODE_W = 5;
  localparam int I_BIT  = 7;
  localparam int F_BIT  = 6;

  // Cause code doubles as the vector slot index
  typedef enum logic [2:0] {
    C_RST = 3'd0, C_UND = 3'd1, C_SWI = 3'd2, C_PABT = 3'd3,
    C_DABT = 3'd4, C_RSVD = 3'd5, C_IRQ = 3'd6, C_FIQ = 3'd7
  } cause_e;

  typedef enum logic [1:0] {
    W_SPSR = 2'd0, W_CPSR = 2'd1, W_LR = 2'd2, W_PC = 2'd3
  } wkind_e;

  function automatic logic [MODE_W-1:0] mode_of(input cause_e c);
    case (c)
      C_FIQ:          return 5'b10001;
      C_IRQ:          return 5'b10010;
      C_PABT, C_DABT: return 5'b10111;
      C_UND:          return 5'b11011;
      default:        return 5'b10011;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] vector_of(input logic [DATA_W-1:0] base,
                                                  input cause_e c);
    return base + {{(DATA_W-5){1'b0}}, c, 2'b00};
  endfunction

  function automatic logic [DATA_W-1:0] ret_adjust(input cause_e c);
    case (c)
      C_PABT, C_IRQ, C_FIQ: return DATA_W'(4);
      C_DABT:               return DATA_W'(8);
      default:              return '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] entry_psr(input logic [DATA_W-1:0] cur,
                                                  input cause_e c);
    logic [DATA_W-1:0] r;
    r = (c == C_RST) ? '0 : cur;
    r[MODE_W-1:0] = mode_of(c);
    r[I_BIT] = 1'b1;
    if (c == C_FIQ || c == C_RST) r[F_BIT] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_undef,
  input  logic   req_swi,
  input  logic   req_pabt,
  input  logic   req_dabt,
  input  logic   req_irq,
  input  logic   req_fiq,
  input  logic   irq_masked,
  input  logic   fiq_masked,
  output logic   take,
  output cause_e cause
);
  logic irq_ok, fiq_ok;
  assign irq_ok = req_irq & ~irq_masked;
  assign fiq_ok = req_fiq & ~fiq_masked;

  always_comb begin
    take  = 1'b1;
    cause = C_RST;
    if      (req_dabt)  cause = C_DABT;
    else if (fiq_ok)    cause = C_FIQ;
    else if (irq_ok)    cause = C_IRQ;
    else if (req_pabt)  cause = C_PABT;
    else if (req_undef) cause = C_UND;
    else if (req_swi)   cause = C_SWI;
    else                take  = 1'b0;
  end

  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_masked |-> !(take && cause == C_IRQ));
  p_fiq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_masked |-> !(take && cause == C_FIQ));
  p_dabt_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_dabt |-> (take && cause == C_DABT));
  p_swi_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cause == C_SWI) |-> !(req_undef || req_pabt || req_dabt));
endmodule

// File: rtl/exc_step_fsm.sv
module exc_step_fsm
  import exc_seq_pkg::*;
#(
  parameter logic [DATA_W-1:0] VEC_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_done,
  input  logic              take,
  input  cause_e            cause,
  input  logic              ret_req,
  input  logic [DATA_W-1:0] pc_in,
  input  logic [DATA_W-1:0] psr_in,
  input  logic [DATA_W-1:0] spsr_in,
  input  logic [DATA_W-1:0] lr_in,
  output logic              busy,
  output logic              wr_en,
  output logic [1:0]        wr_kind,
  output logic [MODE_W-1:0] wr_bank,
  output logic [DATA_W-1:0] wr_data
);
  typedef enum logic [2:0] {
    S_IDLE, S_SAVE, S_SWITCH, S_LINK, S_VEC, S_RESTORE, S_RESUME
  } state_e;

  state_e            state;
  cause_e            cur_cause, last_cause;
  logic              rst_pend;
  logic [DATA_W-1:0] psr_snap, pc_snap, spsr_snap, lr_snap;

  // Named acceptance events
  logic accept_rst, accept_exc, accept_ret;
  assign accept_rst = (state == S_IDLE) && rst_pend;
  assign accept_exc = (state == S_IDLE) && !rst_pend && instr_done && take;
  assign accept_ret = (state == S_IDLE) && !rst_pend && instr_done && !take
                      && ret_req && (last_cause != C_RST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      rst_pend   <= 1'b1;
      cur_cause  <= C_RST;
      last_cause <= C_RST;
      psr_snap   <= '0;
      pc_snap    <= '0;
      spsr_snap  <= '0;
      lr_snap    <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (accept_rst || accept_exc) begin
            rst_pend  <= 1'b0;
            cur_cause <= accept_rst ? C_RST : cause;
            psr_snap  <= psr_in;
            pc_snap   <= pc_in;
            state     <= S_SAVE;
          end else if (accept_ret) begin
            spsr_snap <= spsr_in;
            lr_snap   <= lr_in;
            state     <= S_RESTORE;
          end
        end
        S_SAVE:    state <= S_SWITCH;
        S_SWITCH:  state <= S_LINK;
        S_LINK:    state <= S_VEC;
        S_VEC: begin
          last_cause <= cur_cause;
          state      <= S_IDLE;
        end
        S_RESTORE: state <= S_RESUME;
        default:   state <= S_IDLE;
      endcase
    end
  end

  logic [MODE_W-1:0] tgt_mode;
  assign tgt_mode = mode_of(cur_cause);
  assign busy     = (state != S_IDLE);

  always_comb begin
    wr_en   = 1'b1;
    wr_kind = W_SPSR;
    wr_bank = tgt_mode;
    wr_data = '0;
    case (state)
      S_SAVE:    begin wr_kind = W_SPSR; wr_data = psr_snap; end
      S_SWITCH:  begin wr_kind = W_CPSR; wr_data = entry_psr(psr_snap, cur_cause); end
      S_LINK:    begin wr_kind = W_LR;   wr_data = pc_snap; end
      S_VEC:     begin wr_kind = W_PC;   wr_data = vector_of(VEC_BASE, cur_cause); end
      S_RESTORE: begin wr_kind = W_CPSR; wr_bank = spsr_snap[MODE_W-1:0];
                       wr_data = spsr_snap; end
      S_RESUME:  begin wr_kind = W_PC;   wr_bank = spsr_snap[MODE_W-1:0];
                       wr_data = lr_snap - ret_adjust(last_cause); end
      default:   wr_en = 1'b0;
    endcase
  end

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_en);
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_exc || accept_rst) |=> (busy && wr_en && wr_kind == W_SPSR));
  p_save_switch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_kind == W_SPSR) |=> (wr_en && wr_kind == W_CPSR && $stable(wr_bank)));
  p_switch_link_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SWITCH) |=> (wr_en && wr_kind == W_LR && $stable(wr_bank)));
  p_link_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_kind == W_LR) |=> (wr_kind == W_PC && wr_data[1:0] == 2'b00
      && (wr_data - VEC_BASE) < DATA_W'(32)));
  p_irq_mask_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SWITCH) |-> (wr_data[I_BIT] && wr_data[MODE_W-1:0] == wr_bank));
  p_fiq_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SWITCH && cur_cause == C_FIQ) |-> (wr_data[MODE_W-1:0] == 5'b10001
      && wr_data[F_BIT]));
  p_reset_vec_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_VEC && cur_cause == C_RST) |-> (wr_data == VEC_BASE));
  p_ret_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ret |=> (wr_kind == W_CPSR) ##1 (wr_en && wr_kind == W_PC));
  p_no_reset_return_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && last_cause == C_RST) |=> (state != S_RESTORE));
endmodule

// File: rtl/exc_sequencer.sv
module exc_sequencer
  import exc_seq_pkg::*;
#(
  parameter logic [DATA_W-1:0] VEC_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_done,
  input  logic              req_undef,
  input  logic              req_swi,
  input  logic              req_pabt,
  input  logic              req_dabt,
  input  logic              req_irq,
  input  logic              req_fiq,
  input  logic              ret_req,
  input  logic [DATA_W-1:0] pc_in,
  input  logic [DATA_W-1:0] psr_in,
  input  logic [DATA_W-1:0] spsr_in,
  input  logic [DATA_W-1:0] lr_in,
  output logic              busy,
  output logic              wr_en,
  output logic [1:0]        wr_kind,
  output logic [MODE_W-1:0] wr_bank,
  output logic [DATA_W-1:0] wr_data
);
  logic   take;
  cause_e cause;

  exc_arbiter u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_undef  (req_undef),
    .req_swi    (req_swi),
    .req_pabt   (req_pabt),
    .req_dabt   (req_dabt),
    .req_irq    (req_irq),
    .req_fiq    (req_fiq),
    .irq_masked (psr_in[I_BIT]),
    .fiq_masked (psr_in[F_BIT]),
    .take       (take),
    .cause      (cause)
  );

  exc_step_fsm #(.VEC_BASE(VEC_BASE)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_done (instr_done),
    .take       (take),
    .cause      (cause),
    .ret_req    (ret_req),
    .pc_in      (pc_in),
    .psr_in     (psr_in),
    .spsr_in    (spsr_in),
    .lr_in      (lr_in),
    .busy       (busy),
    .wr_en      (wr_en),
    .wr_kind    (wr_kind),
    .wr_bank    (wr_bank),
    .wr_data    (wr_data)
  );
endmodule

// File: tb/exc_sequencer_test.sv
module exc_sequencer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_done = 1'b0;
  logic req_undef = 1'b0, req_swi = 1'b0, req_pabt = 1'b0;
  logic req_dabt = 1'b0, req_irq = 1'b0, req_fiq = 1'b0;
  logic ret_req = 1'b0;
  logic [31:0] pc_in = '0, psr_in = '0, spsr_in = '0, lr_in = '0;
  logic busy, wr_en;
  logic [1:0] wr_kind;
  logic [4:0] wr_bank;
  logic [31:0] wr_data;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  exc_sequencer uut (
    .clk(clk), .rst_n(rst_n), .instr_done(instr_done),
    .req_undef(req_undef), .req_swi(req_swi), .req_pabt(req_pabt),
    .req_dabt(req_dabt), .req_irq(req_irq), .req_fiq(req_fiq),
    .ret_req(ret_req), .pc_in(pc_in), .psr_in(psr_in),
    .spsr_in(spsr_in), .lr_in(lr_in), .busy(busy), .wr_en(wr_en),
    .wr_kind(wr_kind), .wr_bank(wr_bank), .wr_data(wr_data)
  );

  typedef struct packed {
    logic [5:0]  req;   // {fiq, irq, dabt, pabt, swi, undef}
    logic [31:0] psr;
    logic [31:0] pc;
    logic [31:0] vec;   // all ones: nothing accepted
    logic [4:0]  mode;
    logic [31:0] npsr;
  } row_t;

  localparam int NROWS = 16;
  localparam row_t ROWS [NROWS] = '{
    '{6'b000001, 32'h10,       32'h100, 32'h04, 5'h1B, 32'h9B},
    '{6'b000010, 32'h10,       32'h204, 32'h08, 5'h13, 32'h93},
    '{6'b000100, 32'h2000_0010, 32'h308, 32'h0C, 5'h17, 32'h2000_0097},
    '{6'b001000, 32'h10,       32'h40C, 32'h10, 5'h17, 32'h97},
    '{6'b010000, 32'h10,       32'h510, 32'h18, 5'h12, 32'h92},
    '{6'b100000, 32'h10,       32'h614, 32'h1C, 5'h11, 32'hD1},
    '{6'b111111, 32'h10,       32'h718, 32'h10, 5'h17, 32'h97},
    '{6'b110101, 32'h10,       32'h81C, 32'h1C, 5'h11, 32'hD1},
    '{6'b010110, 32'h10,       32'h920, 32'h18, 5'h12, 32'h92},
    '{6'b000111, 32'h10,       32'hA24, 32'h0C, 5'h17, 32'h97},
    '{6'b000011, 32'h10,       32'hB28, 32'h04, 5'h1B, 32'h9B},
    '{6'b110000, 32'h50,       32'hC2C, 32'h18, 5'h12, 32'hD2},
    '{6'b010000, 32'h90,       32'hD30, 32'hFFFF_FFFF, 5'h0, 32'h0},
    '{6'b100000, 32'hD0,       32'hE34, 32'hFFFF_FFFF, 5'h0, 32'h0},
    '{6'b100000, 32'h90,       32'hF38, 32'h1C, 5'h11, 32'hD1},
    '{6'b000001, 32'h30,       32'h103C, 32'h04, 5'h1B, 32'hBB}
  };

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_write(input logic [1:0] kind, input logic [4:0] bank,
                              input logic [31:0] data, input string tag);
    @(negedge clk);
    check(wr_en === 1'b1 && wr_kind === kind, {tag, " kind"},
          {30'd0, wr_kind}, {30'd0, kind});
    check(wr_bank === bank, {tag, " bank"}, {27'd0, wr_bank}, {27'd0, bank});
    check(wr_data === data, {tag, " data"}, wr_data, data);
  endtask

  task automatic expect_idle(input string tag);
    @(negedge clk);
    check(busy === 1'b0 && wr_en === 1'b0, tag, {30'd0, busy, wr_en}, 32'd0);
  endtask

  task automatic clear_inputs();
    {req_fiq, req_irq, req_dabt, req_pabt, req_swi, req_undef} = 6'b0;
    instr_done = 1'b0;
    ret_req = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    clear_inputs();
    repeat (2) @(negedge clk);
    check(busy === 1'b0 && wr_en === 1'b0, "R1 quiet in reset",
          {30'd0, busy, wr_en}, 32'd0);
    psr_in = 32'h1F;
    pc_in  = 32'h0000_0ABC;
    rst_n  = 1'b1;
    // R1: reset sequence runs without instr_done
    expect_write(2'd0, 5'h13, 32'h1F,       "R1 reset save");
    expect_write(2'd1, 5'h13, 32'h0000_00D3, "R1 reset status");
    expect_write(2'd2, 5'h13, 32'h0000_0ABC, "R1 reset link");
    expect_write(2'd3, 5'h13, 32'h0000_0000, "R1 reset vector");
    expect_idle("R1 idle after reset sequence");
  endtask

  function automatic logic [31:0] adj_for_vec(input logic [31:0] v);
    if (v == 32'h0C || v == 32'h18 || v == 32'h1C) return 32'd4;
    if (v == 32'h10) return 32'd8;
    return 32'd0;
  endfunction

  task automatic do_return(input logic [31:0] spsr, input logic [31:0] lr,
                           input logic [31:0] exp_pc, input string tag);
    ret_req = 1'b1; instr_done = 1'b1; spsr_in = spsr; lr_in = lr;
    expect_write(2'd1, spsr[4:0], spsr, {tag, " R9 restore"});
    clear_inputs();
    expect_write(2'd3, spsr[4:0], exp_pc, {tag, " R9 resume"});
    expect_idle({tag, " R9 idle"});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    do_reset();
    // R10: reset is never returned from
    @(negedge clk);
    ret_req = 1'b1; instr_done = 1'b1; spsr_in = 32'h10; lr_in = 32'h40;
    expect_idle("R10 return after reset ignored");
    clear_inputs();
    expect_idle("R10 still idle");

    // Table: R2 R3 R4 R5 R6 R8 with a return (R9) after every entry
    for (int i = 0; i < NROWS; i++) begin
      {req_fiq, req_irq, req_dabt, req_pabt, req_swi, req_undef} = ROWS[i].req;
      psr_in = ROWS[i].psr;
      pc_in  = ROWS[i].pc;
      instr_done = 1'b1;
      if (ROWS[i].vec == 32'hFFFF_FFFF) begin
        expect_idle($sformatf("R8 row %0d masked request ignored", i));
        clear_inputs();
      end else begin
        expect_write(2'd0, ROWS[i].mode, ROWS[i].psr,
                     $sformatf("R2 R6 row %0d save", i));
        clear_inputs();
        expect_write(2'd1, ROWS[i].mode, ROWS[i].npsr,
                     $sformatf("R4 R5 row %0d status", i));
        expect_write(2'd2, ROWS[i].mode, ROWS[i].pc,
                     $sformatf("R2 row %0d link", i));
        expect_write(2'd3, ROWS[i].mode, ROWS[i].vec,
                     $sformatf("R3 row %0d vector", i));
        expect_idle($sformatf("R2 row %0d idle", i));
        do_return(ROWS[i].psr, ROWS[i].pc, ROWS[i].pc - adj_for_vec(ROWS[i].vec),
                  $sformatf("row %0d", i));
      end
    end

    // R7: no acceptance without instr_done
    psr_in = 32'h10;
    req_swi = 1'b1; instr_done = 1'b0;
    expect_idle("R7 request without instr_done");
    expect_idle("R7 still idle");
    clear_inputs();

    // R7: requests while busy are ignored
    pc_in = 32'h2000; req_undef = 1'b1; instr_done = 1'b1;
    expect_write(2'd0, 5'h1B, 32'h10, "R7 entry save");
    req_undef = 1'b0; req_fiq = 1'b1; req_dabt = 1'b1;
    expect_write(2'd1, 5'h1B, 32'h9B, "R7 busy status unchanged");
    expect_write(2'd2, 5'h1B, 32'h2000, "R7 busy link unchanged");
    expect_write(2'd3, 5'h1B, 32'h04, "R7 busy vector unchanged");
    clear_inputs();
    expect_idle("R7 no second sequence");
    do_return(32'h10, 32'h2000, 32'h2000, "R9 undefined no adjust");

    // R10: exception beats a return in the same cycle
    pc_in = 32'h3000; req_irq = 1'b1; ret_req = 1'b1; instr_done = 1'b1;
    spsr_in = 32'h10; lr_in = 32'h44;
    expect_write(2'd0, 5'h12, 32'h10, "R10 exception over return");
    clear_inputs();
    expect_write(2'd1, 5'h12, 32'h92, "R10 status");
    expect_write(2'd2, 5'h12, 32'h3000, "R10 link");
    expect_write(2'd3, 5'h12, 32'h18, "R10 vector");
    expect_idle("R10 idle");

    // R1 and R10 again after a mid-run reset
    do_reset();
    ret_req = 1'b1; instr_done = 1'b1;
    expect_idle("R10 return blocked after second reset");
    clear_inputs();

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule